// File: doc/BRIEF.md
# Double-Buffered Frame Base Address Registers

This block holds the frame-buffer start addresses for the two panels of a display controller, one for the upper half and one for the lower half of a split panel. Each panel has two registers. Software writes the staged register. The active register drives the pixel fetch engine. The active register changes only when a vertical-sync strobe arrives, so software can prepare the next frame's buffer at any point in the current frame without the image tearing.

Every vertical-sync strobe copies both staged addresses into their active registers and sets a sticky update flag. Software clears the flag by writing a one to the status register. An interrupt line is driven high while the flag is set and the mask bit allows it. Addresses are kept 8-byte aligned: the three low address bits are dropped on write and are always zero on the outputs.

Register map (byte offsets, `reg_addr[3:2]` selects the word): 0x0 upper staged base, 0x4 lower staged base, 0x8 interrupt enable (bit 0), 0xC status (bit 0 = update flag; write 1 to clear).

Top module: `fbr_top`

## Requirements
- R1: After reset, both staged registers, both active outputs, the update flag and the interrupt enable are zero, and `irq` is low.
- R2: A write to offset 0x0 (upper) or 0x4 (lower) stores `reg_wdata` with bits 2:0 forced to zero; a read of the same offset returns the stored value, and a write to one panel leaves the other unchanged.
- R3: A write to a staged register does not change either active output, whether or not a strobe has arrived earlier.
- R4: When `vsync` is high at a rising clock edge, both active outputs take their panel's staged value, visible after that edge.
- R5: When a staged write and `vsync` fall on the same edge, the active output takes the staged value held before that write, and the newly written value moves across at the next strobe.
- R6: A `vsync` edge sets the update flag, seen on `upd_flag` and in bit 0 of a read from offset 0xC after that edge.
- R7: Writing a word with bit 0 set to offset 0xC clears the flag; a write with bit 0 clear leaves it unchanged.
- R8: When a clear write and `vsync` fall on the same edge, the flag ends up set.
- R9: `irq` is high exactly when the flag is set and bit 0 of the enable register at offset 0x8 is one; the enable reads back at offset 0x8 bit 0.
- R10: Bits 2:0 of both active outputs are zero at all times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 4 | Byte offset of the register accessed |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr`, combinational |
| vsync | input | 1 | One-cycle vertical-sync strobe |
| upper_base | output | 32 | Active upper-panel frame base |
| lower_base | output | 32 | Active lower-panel frame base |
| upd_flag | output | 1 | Sticky update flag |
| irq | output | 1 | Update interrupt |

## Verification
The assertions assume that `vsync` is a strobe sampled on the rising edge and that `reg_addr` and `reg_wdata` are stable while `reg_wr` is high; nothing else is assumed about how often strobes or writes come. The bench drives every input on the falling edge and holds it for one full cycle, so each write or strobe is seen at exactly one rising edge. The same-edge cases (write with strobe, clear with strobe) are produced by raising both inputs in the same falling-edge slot.

// File: rtl/fbr_pkg.sv
package fbr_pkg;
  localparam int DATA_W     = 32;
  localparam int ALIGN_BITS = 3;
  localparam int ADDR_W     = 4;

  typedef enum logic [1:0] {
    W_UPPER  = 2'd0,
    W_LOWER  = 2'd1,
    W_ENABLE = 2'd2,
    W_STATUS = 2'd3
  } fbr_word_e;

  // Drop the sub-doubleword bits of an address.
  function automatic logic [DATA_W-1:0] fbr_align(input logic [DATA_W-1:0] v);
    return {v[DATA_W-1:ALIGN_BITS], {ALIGN_BITS{1'b0}}};
  endfunction

  // Map a byte offset onto the register word it selects.
  function automatic fbr_word_e fbr_decode(input logic [ADDR_W-1:0] a);
    return fbr_word_e'(a[ADDR_W-1:2]);
  endfunction
endpackage

// File: rtl/fbr_bank.sv
module fbr_bank
  import fbr_pkg::*;
#(
  parameter int DW = DATA_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [DW-1:0] wdata,
  input  logic          load,
  output logic [DW-1:0] staged,
  output logic [DW-1:0] active
);
  logic [DW-1:0] staged_q, active_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      staged_q <= '0;
      active_q <= '0;
    end else begin
      if (wr_en) staged_q <= fbr_align(wdata);
      if (load)  active_q <= staged_q;
    end
  end

  assign staged = staged_q;
  assign active = active_q;

  // R3
  active_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> $stable(active_q));
  // R4
  active_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> active_q == $past(staged_q));
  // R10
  active_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
    active_q[ALIGN_BITS-1:0] == '0);
  // R2
  staged_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(staged_q));
endmodule

// File: rtl/fbr_status.sv
module fbr_status (
  input  logic clk,
  input  logic rst_n,
  input  logic set_evt,
  input  logic clr_evt,
  input  logic en_wr,
  input  logic en_din,
  output logic enable,
  output logic flag,
  output logic irq
);
  logic flag_q, en_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flag_q <= 1'b0;
      en_q   <= 1'b0;
    end else begin
      if (set_evt)      flag_q <= 1'b1;
      else if (clr_evt) flag_q <= 1'b0;
      if (en_wr) en_q <= en_din;
    end
  end

  assign enable = en_q;
  assign flag   = flag_q;
  assign irq    = flag_q & en_q;

  // R6, R8
  flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    set_evt |=> flag_q);
  // R7
  flag_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr_evt && !set_evt |=> !flag_q);
  // R7
  flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !set_evt && !clr_evt |=> $stable(flag_q));
  // R9
  irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en_q |-> !irq);
endmodule

// File: rtl/fbr_top.sv
module fbr_top
  import fbr_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic              vsync,
  output logic [DATA_W-1:0] upper_base,
  output logic [DATA_W-1:0] lower_base,
  output logic              upd_flag,
  output logic              irq
);
  localparam int PANELS = 2;

  fbr_word_e   sel;
  logic [PANELS-1:0] panel_wr;
  logic [DATA_W-1:0] staged [PANELS];
  logic [DATA_W-1:0] active [PANELS];
  logic        en_wr, clr_evt, enable;

  assign sel     = fbr_decode(reg_addr);
  assign en_wr   = reg_wr && (sel == W_ENABLE);
  assign clr_evt = reg_wr && (sel == W_STATUS) && reg_wdata[0];

  for (genvar p = 0; p < PANELS; p++) begin : g_panel
    assign panel_wr[p] = reg_wr && (sel == fbr_word_e'(p));
    fbr_bank #(.DW(DATA_W)) u_bank (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr_en  (panel_wr[p]),
      .wdata  (reg_wdata),
      .load   (vsync),
      .staged (staged[p]),
      .active (active[p])
    );
  end

  fbr_status u_status (
    .clk     (clk),
    .rst_n   (rst_n),
    .set_evt (vsync),
    .clr_evt (clr_evt),
    .en_wr   (en_wr),
    .en_din  (reg_wdata[0]),
    .enable  (enable),
    .flag    (upd_flag),
    .irq     (irq)
  );

  assign upper_base = active[0];
  assign lower_base = active[1];

  always_comb begin
    reg_rdata = '0;
    unique case (sel)
      W_UPPER:  reg_rdata = staged[0];
      W_LOWER:  reg_rdata = staged[1];
      W_ENABLE: reg_rdata[0] = enable;
      W_STATUS: reg_rdata[0] = upd_flag;
      default:  reg_rdata = '0;
    endcase
  end

  // R2
  one_panel_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(panel_wr));
  // R9
  irq_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> upd_flag);
endmodule

// File: tb/fbr_top_test.sv
module fbr_top_test;
  logic        clk = 0, rst_n = 0, reg_wr = 0, vsync = 0;
  logic [3:0]  reg_addr = 0;
  logic [31:0] reg_wdata = 0, reg_rdata, upper_base, lower_base;
  logic        upd_flag, irq;
  int tests = 0, fails = 0;

  always #10 clk = ~clk;

  fbr_top uut (.*);

  function automatic logic [31:0] al(input logic [31:0] v);
    return v & ~32'h7;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d, input logic vs = 0);
    @(negedge clk);
    reg_wr = 1; reg_addr = a; reg_wdata = d; vsync = vs;
    @(negedge clk);
    reg_wr = 0; vsync = 0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a; #1 d = reg_rdata;
  endtask

  task automatic pulse();
    @(negedge clk); vsync = 1;
    @(negedge clk); vsync = 0;
  endtask

  task automatic t_reset();
    logic [31:0] d;
    rd(4'h0, d); chk("R1 upper staged", d, 0);
    rd(4'h4, d); chk("R1 lower staged", d, 0);
    rd(4'h8, d); chk("R1 enable", d, 0);
    chk("R1 upper active", upper_base, 0);
    chk("R1 lower active", lower_base, 0);
    chk("R1 flag", upd_flag, 0);
    chk("R1 irq", irq, 0);
  endtask

  task automatic t_write_read();
    logic [31:0] d;
    wr(4'h0, 32'h1234_567F);
    rd(4'h0, d); chk("R2 upper readback", d, al(32'h1234_567F));
    rd(4'h4, d); chk("R2 lower untouched", d, 0);
    wr(4'h4, 32'hCAFE_0003);
    rd(4'h4, d); chk("R2 lower readback", d, al(32'hCAFE_0003));
    rd(4'h0, d); chk("R2 upper untouched", d, al(32'h1234_567F));
    chk("R3 upper active no change", upper_base, 0);
    chk("R3 lower active no change", lower_base, 0);
  endtask

  task automatic t_vsync_load();
    pulse();
    chk("R4 upper loaded", upper_base, al(32'h1234_567F));
    chk("R4 lower loaded", lower_base, al(32'hCAFE_0003));
    chk("R10 upper low bits", {29'd0, upper_base[2:0]}, 0);
    chk("R10 lower low bits", {29'd0, lower_base[2:0]}, 0);
    chk("R6 flag set", upd_flag, 1);
    wr(4'h0, 32'hAAAA_5555);
    chk("R3 active held after write", upper_base, al(32'h1234_567F));
  endtask

  task automatic t_same_edge();
    wr(4'h0, 32'h0BAD_F00D, 1'b1);
    chk("R5 old staged taken", upper_base, al(32'hAAAA_5555));
    pulse();
    chk("R5 new staged next strobe", upper_base, al(32'h0BAD_F00D));
  endtask

  task automatic t_clear();
    logic [31:0] d;
    rd(4'hC, d); chk("R6 status read", d, 1);
    wr(4'hC, 32'hFFFF_FFFE);
    chk("R7 write zero keeps flag", upd_flag, 1);
    wr(4'hC, 32'h1);
    chk("R7 clear", upd_flag, 0);
    rd(4'hC, d); chk("R7 status read cleared", d, 0);
    pulse();
    wr(4'hC, 32'h1, 1'b1);
    chk("R8 set beats clear", upd_flag, 1);
  endtask

  task automatic t_irq();
    logic [31:0] d;
    chk("R9 masked irq", irq, 0);
    wr(4'h8, 32'h1);
    rd(4'h8, d); chk("R9 enable readback", d, 1);
    chk("R9 irq asserted", irq, 1);
    wr(4'hC, 32'h1);
    chk("R9 irq drops with flag", irq, 0);
    pulse();
    chk("R9 irq on strobe", irq, 1);
    wr(4'h8, 32'h0);
    chk("R9 irq masked again", irq, 0);
  endtask

  initial begin
    fork
      begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        t_reset();
        t_write_read();
        t_vsync_load();
        t_same_edge();
        t_clear();
        t_irq();
      end
      begin
        repeat (5000) @(posedge clk);
        tests++; fails++;
        $display("FAIL watchdog: got timeout expected completion");
      end
    join_any
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule